// File: doc/BRIEF.md
# Credit-Bucket Output Rate Limiter

This block decides when an output port may begin sending a packet. It keeps one signed credit counter that earns a fixed 16 credits on every clock. When a packet start is accepted, the counter is charged two costs at once. One is a per-packet cost, programmed in units of 256 credits. The other is a per-word cost in single credits, charged once for each 64-bit data word of the packet.

The counter is clamped at a ceiling of `creditLimit` × 256, which sets the largest burst that can pass back to back. A start is granted while the counter is zero or positive, and the charge may drive it negative. The port then waits until the earned credit brings the counter back to zero. A per-word cost of zero gives pure packet-rate limiting. For bit-rate limiting, software sets the per-packet cost to cover the 24 bytes of per-packet overhead (inter-frame gap, preamble and CRC) that the word count leaves out.

When the block is disabled, it grants every start without charging and keeps the counter parked at the ceiling. Reset is synchronous and also loads the ceiling.

Top module: `token_rate_limiter`

## Requirements
- R1: A clock edge with `rstN` low loads `credit` with `creditLimit`×256. With `enable` high after reset, `permit` reads 1.
- R2: With `enable` high and no accepted start, each clock edge raises `credit` by exactly 16, as long as the result does not exceed the ceiling.
- R3: `credit` never exceeds the ceiling (`creditLimit`×256, sampled at the updating edge). A sum that would pass it is clamped to it, and lowering `creditLimit` pulls `credit` down to the new ceiling on the next edge.
- R4: An accepted start (`startReq` high while `permit` is high and `enable` high) gives next credit = min(credit + 16 − (`costPkt`×256 + `startWords`×`costWord`), ceiling). Earning and charging happen in the same update.
- R5: When `costWord` is 0, the charge is `costPkt`×256 whatever `startWords` holds.
- R6: While `enable` is high, `permit` is 1 exactly when `credit` ≥ 0. A credit of exactly zero grants a start.
- R7: A `startReq` that arrives while `permit` is 0 is ignored. `credit` only earns its 16 per edge.
- R8: While `enable` is low, `permit` is 1 in the same cycle, each edge loads `credit` with the ceiling, and starts are not charged.
- R9: `credit` is a two's-complement signed value and may go below zero after a charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Limiting active when high |
| costPkt | input | PKT_W | Per-packet cost, units of 256 credits |
| costWord | input | WC_W | Per-64-bit-word cost, single credits |
| creditLimit | input | LIM_W | Ceiling, units of 256 credits |
| startReq | input | 1 | Request to start a packet this cycle |
| startWords | input | WORDS_W | Word count of the requested packet |
| permit | output | 1 | Start may proceed this cycle |
| credit | output | CRED_W | Current signed credit level |

## Verification
The fragile point is an edge where earning and charging coincide. This includes a start taken right at the ceiling, where the combined update must keep the 16 earned credits instead of clamping first and charging afterwards. The bench provokes this from a full bucket and expects ceiling + 16 − cost. It also holds a request while the counter climbs from negative through zero. The request must be refused at −16 and granted exactly at 0. After that grant the counter must read 16 − cost.

// File: rtl/rate_limit_pkg.sv
package rate_limit_pkg;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // width of the largest single charge: packet part plus word part, one carry bit
  function automatic int costWidth(input int pktW, input int wcW, input int wordsW);
    return maxOf(pktW + 8, wcW + wordsW) + 1;
  endfunction

  // signed credit: ceiling or cost magnitude, plus earn headroom and sign
  function automatic int creditWidth(input int pktW, input int wcW, input int wordsW,
                                     input int limW);
    return maxOf(limW + 8, costWidth(pktW, wcW, wordsW)) + 2;
  endfunction

  typedef struct packed {
    logic loadCeil;  // force counter to ceiling (reset or disabled)
    logic advance;   // normal earn/clamp update
    logic charge;    // subtract the packet charge in this update
  } credit_ctrl_t;

endpackage

// File: rtl/rate_cost_calc.sv
module rate_cost_calc #(
  parameter int PKT_W   = 12,
  parameter int WC_W    = 12,
  parameter int WORDS_W = 12,
  parameter int COST_W  = 25
) (
  input  logic [PKT_W-1:0]   costPkt,
  input  logic [WC_W-1:0]    costWord,
  input  logic [WORDS_W-1:0] startWords,
  output logic [COST_W-1:0]  cost
);
  logic [COST_W-1:0] pktPart;
  logic [COST_W-1:0] wordPart;

  always_comb begin
    pktPart  = COST_W'({costPkt, 8'h00});
    wordPart = COST_W'(startWords) * COST_W'(costWord);
    cost     = pktPart + wordPart;
  end
endmodule

// File: rtl/rate_credit_dp.sv
module rate_credit_dp
  import rate_limit_pkg::*;
#(
  parameter int LIM_W  = 16,
  parameter int COST_W = 25,
  parameter int CRED_W = 27,
  parameter int EARN   = 16
) (
  input  logic                     clk,
  input  credit_ctrl_t             ctrl,
  input  logic [LIM_W-1:0]         creditLimit,
  input  logic [COST_W-1:0]        cost,
  output logic signed [CRED_W-1:0] credit,
  output logic                     nonNeg
);
  localparam int CEIL_PAD = CRED_W - LIM_W - 8;
  localparam int COST_PAD = CRED_W - COST_W;

  logic signed [CRED_W-1:0] ceiling;
  logic signed [CRED_W-1:0] charge;
  logic signed [CRED_W-1:0] sum;
  logic signed [CRED_W-1:0] creditNext;

  always_comb begin
    ceiling = $signed({{CEIL_PAD{1'b0}}, creditLimit, 8'h00});
    charge  = ctrl.charge ? $signed({{COST_PAD{1'b0}}, cost}) : '0;
    sum     = credit + CRED_W'(EARN) - charge;
    if (ctrl.loadCeil)     creditNext = ceiling;
    else if (ctrl.advance) creditNext = (sum > ceiling) ? ceiling : sum;
    else                   creditNext = credit;
  end

  always_ff @(posedge clk) begin
    credit <= creditNext;
  end

  assign nonNeg = ~credit[CRED_W-1];
endmodule

// File: rtl/rate_limit_ctrl.sv
module rate_limit_ctrl
  import rate_limit_pkg::*;
(
  input  logic         rstN,
  input  logic         enable,
  input  logic         startReq,
  input  logic         nonNeg,
  output logic         permit,
  output credit_ctrl_t ctrl
);
  logic active;

  always_comb begin
    active        = rstN & enable;
    permit        = ~enable | nonNeg;
    ctrl.loadCeil = ~active;
    ctrl.advance  = active;
    ctrl.charge   = active & startReq & nonNeg;
  end
endmodule

// File: rtl/token_rate_limiter.sv
module token_rate_limiter
  import rate_limit_pkg::*;
#(
  parameter int PKT_W   = 12,
  parameter int WC_W    = 12,
  parameter int WORDS_W = 12,
  parameter int LIM_W   = 16,
  parameter int CRED_W  = creditWidth(PKT_W, WC_W, WORDS_W, LIM_W)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [PKT_W-1:0]         costPkt,
  input  logic [WC_W-1:0]          costWord,
  input  logic [LIM_W-1:0]         creditLimit,
  input  logic                     startReq,
  input  logic [WORDS_W-1:0]       startWords,
  output logic                     permit,
  output logic signed [CRED_W-1:0] credit
);
  localparam int COST_W = costWidth(PKT_W, WC_W, WORDS_W);
  localparam int EARN   = 16;

  credit_ctrl_t      ctrl;
  logic [COST_W-1:0] cost;
  logic              nonNeg;

  rate_cost_calc #(
    .PKT_W(PKT_W), .WC_W(WC_W), .WORDS_W(WORDS_W), .COST_W(COST_W)
  ) u_cost (
    .costPkt(costPkt), .costWord(costWord), .startWords(startWords), .cost(cost)
  );

  rate_limit_ctrl u_ctrl (
    .rstN(rstN), .enable(enable), .startReq(startReq), .nonNeg(nonNeg),
    .permit(permit), .ctrl(ctrl)
  );

  rate_credit_dp #(
    .LIM_W(LIM_W), .COST_W(COST_W), .CRED_W(CRED_W), .EARN(EARN)
  ) u_dp (
    .clk(clk), .ctrl(ctrl), .creditLimit(creditLimit), .cost(cost),
    .credit(credit), .nonNeg(nonNeg)
  );
endmodule

// File: rtl/token_rate_limiter_chk.sv
module token_rate_limiter_chk #(
  parameter int LIM_W  = 16,
  parameter int CRED_W = 27
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     enable,
  input logic                     startReq,
  input logic [LIM_W-1:0]         creditLimit,
  input logic                     permit,
  input logic signed [CRED_W-1:0] credit
);
  logic signed [CRED_W-1:0] ceilChk;
  assign ceilChk = $signed(CRED_W'({creditLimit, 8'h00}));

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> credit <= $past(ceilChk));

  // R2
  a_r2_earn_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !startReq && (credit + 16 <= ceilChk)) |=> credit == $past(credit) + 16);

  // R6
  a_r6_permit_sign: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (permit == (credit >= 0)));

  // R7
  a_r7_blocked_only_earns: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !permit) |=> credit == $past(credit) + 16);

  // R8
  a_r8_disabled_parks: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> credit == $past(ceilChk));

  // R8
  a_r8_disabled_permit: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> permit);
endmodule

bind token_rate_limiter token_rate_limiter_chk #(.LIM_W(LIM_W), .CRED_W(CRED_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
  .creditLimit(creditLimit), .permit(permit), .credit(credit)
);

// File: tb/token_rate_limiter_bench.sv
module token_rate_limiter_bench;
  localparam int PERIOD  = 10;
  localparam int PKT_W   = 12;
  localparam int WC_W    = 12;
  localparam int WORDS_W = 12;
  localparam int LIM_W   = 16;
  localparam int CRED_W  = 27;

  logic clk = 0;
  logic rstN, enable, startReq, permit;
  logic [PKT_W-1:0] costPkt;
  logic [WC_W-1:0] costWord;
  logic [LIM_W-1:0] creditLimit;
  logic [WORDS_W-1:0] startWords;
  logic signed [CRED_W-1:0] credit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  token_rate_limiter #(.PKT_W(PKT_W), .WC_W(WC_W), .WORDS_W(WORDS_W), .LIM_W(LIM_W),
                       .CRED_W(CRED_W)) u_token_rate_limiter (
    .clk(clk), .rstN(rstN), .enable(enable), .costPkt(costPkt), .costWord(costWord),
    .creditLimit(creditLimit), .startReq(startReq), .startWords(startWords),
    .permit(permit), .credit(credit)
  );

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int cr();
    return int'(credit);
  endfunction

  task automatic refill();
    startReq = 0; enable = 0; step(); enable = 1;
  endtask

  task automatic t_reset();
    rstN = 0; enable = 1; creditLimit = 2; costPkt = 1; costWord = 8;
    startWords = 4; startReq = 0;
    step(2);
    rstN = 1; #1;
    check("R1 credit after reset", cr(), 512);
    check("R1 permit after reset", int'(permit), 1);
    step(3);
    check("R3 idle at ceiling", cr(), 512);
  endtask

  task automatic t_charge();
    refill();
    costPkt = 1; costWord = 8; startWords = 4; startReq = 1;
    step();
    startReq = 0;
    check("R4 charge from full bucket", cr(), 240);
    step(3);
    check("R2 earn 16 per cycle", cr(), 288);
  endtask

  task automatic t_negative();
    refill();
    costPkt = 3; startWords = 0; startReq = 1;
    step();
    check("R9 credit negative", cr(), -240);
    check("R6 permit low when negative", int'(permit), 0);
    step(14);
    check("R7 held request ignored", cr(), -16);
    check("R6 permit low at -16", int'(permit), 0);
    startReq = 0;
    step();
    check("R6 credit reaches zero", cr(), 0);
    check("R6 permit at zero", int'(permit), 1);
    startReq = 1;
    step();
    startReq = 0;
    check("R6 start granted at zero", cr(), -752);
  endtask

  task automatic t_pure_pkt();
    refill();
    costPkt = 1; costWord = 0; startWords = 100; startReq = 1;
    step();
    startReq = 0;
    check("R5 word count ignored", cr(), 272);
  endtask

  task automatic t_disable();
    refill();
    costPkt = 3; costWord = 0; startWords = 0; startReq = 1;
    step();
    startReq = 0;
    check("R9 negative before disable", cr(), -240);
    enable = 0; #1;
    check("R8 permit while disabled", int'(permit), 1);
    step();
    check("R8 credit parked at ceiling", cr(), 512);
    startReq = 1;
    step();
    startReq = 0;
    check("R8 start not charged", cr(), 512);
    enable = 1;
  endtask

  task automatic t_limit();
    refill();
    creditLimit = 1;
    step();
    check("R3 clamp to lowered ceiling", cr(), 256);
    creditLimit = 2;
    step();
    check("R2 earn after raise", cr(), 272);
  endtask

  task automatic t_saturate();
    refill();
    costPkt = 0; costWord = 28; startWords = 1; startReq = 1;
    step();
    startReq = 0;
    check("R4 word-only charge", cr(), 500);
    step();
    check("R3 saturate at ceiling", cr(), 512);
  endtask

  initial begin
    t_reset();
    t_charge();
    t_negative();
    t_pure_pkt();
    t_disable();
    t_limit();
    t_saturate();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule